// File: doc/BRIEF.md
# Asymmetric Aspect-Ratio Dual-Port RAM

This block is a two-port synchronous memory that shows one storage array through two views. Port A is the wide view: each address holds a full word of `WIDE_W` bits and there are `WIDE_DEPTH` such words. Port B is the narrow view: each word is `WIDE_W/RATIO` bits wide and there are `WIDE_DEPTH*RATIO` of them. The two views cover exactly the same bits, so what one port writes the other port can read.

A typical use is to write full words on the wide side and read them back one lane at a time on the narrow side, or the other way round, without an external multiplexer or repacking stage. Both ports run from one shared clock and are otherwise independent. Each port has its own enable, write enable, address, write data and registered read data. A narrow write acts as a sub-word write into the wide word and leaves the other lanes alone.

`RATIO` must be 1, 2, 4 or 8. It must divide `WIDE_W`, and `WIDE_DEPTH` must be a power of two of at least 2. Any other configuration stops elaboration with an error.

Top module: `asym_dpram`

## Requirements
- R1: A wide write (`en_a`=1, `we_a`=1) stores `wdata_a` at row `addr_a`. A later wide read of that row returns it on `rdata_a`, valid right after the clock edge that sampled the read address.
- R2: A narrow address splits into a row part and a lane part. The row is `addr_b[NARROW_AW-1:LANE_AW]` and the lane is `addr_b[LANE_AW-1:0]`. Lane k covers wide bits `[k*NARROW_W +: NARROW_W]`, so lane 0 is the least-significant slice. A narrow read returns that slice on `rdata_b` one edge later.
- R3: A narrow write changes only the addressed lane of the addressed row. All other lanes of that wide word keep their contents.
- R4: Both views reach the full capacity. The highest narrow address (`WIDE_DEPTH*RATIO-1`) is the top lane of the top row, and narrow address 0 is lane 0 of row 0.
- R5: Reads are read-first. A read on the same edge as a write to the same bits, from either port, returns the contents from before that write.
- R6: While a port's enable is low, its read data holds its previous value. A write strobe on that port has no effect on the memory, even with `we` high.
- R7: Writes from both ports on the same edge to bits that do not overlap both take effect.
- R8: While `rst_n` is low, `rdata_a` and `rdata_b` read zero, and they stay zero after release until the next read. Reset does not alter the stored contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en_a | input | 1 | Wide port access enable |
| we_a | input | 1 | Wide port write enable (takes effect only with en_a) |
| addr_a | input | ROW_AW | Wide port row address |
| wdata_a | input | WIDE_W | Wide port write data |
| rdata_a | output | WIDE_W | Wide port registered read data |
| en_b | input | 1 | Narrow port access enable |
| we_b | input | 1 | Narrow port write enable (takes effect only with en_b) |
| addr_b | input | NARROW_AW | Narrow port address (row bits above lane bits) |
| wdata_b | input | NARROW_W | Narrow port write data |
| rdata_b | output | NARROW_W | Narrow port registered read data |

## Verification
Every read result appears one clock after the edge that sampled an enabled address. This is the same on both ports, for pure reads and for read-first returns during writes. The bench therefore updates its expected read data and its shadow memory when it applies the inputs of a cycle. It compares both read outputs one time unit after the next rising edge, which is exactly when each new result is due. After a reset release, the zero read data is checked once the synchronizer has let go, two edges later. Stored contents that must survive that reset are only checked by the reads that follow it.

// File: rtl/asym_dpram_pkg.sv
package asym_dpram_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  function automatic bit cfg_is_legal(input int unsigned ratio,
                                      input int unsigned wide_w,
                                      input int unsigned wide_depth);
    bit ratio_ok;
    bit depth_ok;
    ratio_ok = (ratio == 1) || (ratio == 2) || (ratio == 4) || (ratio == 8);
    depth_ok = (wide_depth >= 2) && ((wide_depth & (wide_depth - 1)) == 0);
    return ratio_ok && depth_ok && (wide_w >= ratio) && ((wide_w % ratio) == 0);
  endfunction

endpackage

// File: rtl/asym_dpram_rst_sync.sv
module asym_dpram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[1];

endmodule

// File: rtl/asym_dpram_port_ctl.sv
module asym_dpram_port_ctl
  import asym_dpram_pkg::*;
(
  input  logic      en,
  input  logic      we,
  output acc_kind_e kind,
  output logic      rd,
  output logic      wr
);

  always_comb begin
    if (!en) begin
      kind = ACC_IDLE;
    end else if (we) begin
      kind = ACC_WRITE;
    end else begin
      kind = ACC_READ;
    end
  end

  // Every enabled access reads (read-first), only writes store.
  assign rd = (kind != ACC_IDLE);
  assign wr = (kind == ACC_WRITE);

endmodule

// File: rtl/asym_dpram_lane_bank.sv
module asym_dpram_lane_bank #(
  parameter  int unsigned LANE_W = 8,
  parameter  int unsigned DEPTH  = 16,
  localparam int unsigned ROW_AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_rd,
  input  logic              a_wr,
  input  logic [ROW_AW-1:0] a_row,
  input  logic [LANE_W-1:0] a_wdata,
  output logic [LANE_W-1:0] a_rdata,
  input  logic              b_rd,
  input  logic              b_wr,
  input  logic [ROW_AW-1:0] b_row,
  input  logic [LANE_W-1:0] b_wdata,
  output logic [LANE_W-1:0] b_rdata
);

  logic [LANE_W-1:0] store [DEPTH];
  logic [LANE_W-1:0] a_q, a_d;
  logic [LANE_W-1:0] b_q, b_d;
  logic              b_blocked;

  // Same row written by both ports in this lane: wide port wins.
  assign b_blocked = a_wr && (a_row == b_row);

  always_ff @(posedge clk) begin
    if (a_wr) begin
      store[a_row] <= a_wdata;
    end
    if (b_wr && !b_blocked) begin
      store[b_row] <= b_wdata;
    end
  end

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (a_rd) begin
      a_d = store[a_row];
    end
    if (b_rd) begin
      b_d = store[b_row];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign a_rdata = a_q;
  assign b_rdata = b_q;

endmodule

// File: rtl/asym_dpram_lane_mux.sv
module asym_dpram_lane_mux #(
  parameter  int unsigned LANE_W = 8,
  parameter  int unsigned RATIO  = 4,
  localparam int unsigned SEL_W  = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic [RATIO*LANE_W-1:0] lanes,
  input  logic [SEL_W-1:0]        sel,
  output logic [LANE_W-1:0]       out
);

  generate
    if (RATIO == 1) begin : g_pass
      logic unused_sel;
      assign unused_sel = ^sel;
      assign out = lanes;
    end else begin : g_pick
      assign out = lanes[sel*LANE_W +: LANE_W];
    end
  endgenerate

endmodule

// File: rtl/asym_dpram.sv
module asym_dpram
  import asym_dpram_pkg::*;
#(
  parameter  int unsigned WIDE_W       = 32,
  parameter  int unsigned RATIO        = 4,
  parameter  int unsigned WIDE_DEPTH   = 16,
  localparam int unsigned NARROW_W     = WIDE_W / RATIO,
  localparam int unsigned NARROW_DEPTH = WIDE_DEPTH * RATIO,
  localparam int unsigned ROW_AW       = $clog2(WIDE_DEPTH),
  localparam int unsigned LANE_AW      = $clog2(RATIO),
  localparam int unsigned NARROW_AW    = $clog2(NARROW_DEPTH),
  localparam int unsigned SEL_W        = (LANE_AW > 0) ? LANE_AW : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_a,
  input  logic                 we_a,
  input  logic [ROW_AW-1:0]    addr_a,
  input  logic [WIDE_W-1:0]    wdata_a,
  output logic [WIDE_W-1:0]    rdata_a,
  input  logic                 en_b,
  input  logic                 we_b,
  input  logic [NARROW_AW-1:0] addr_b,
  input  logic [NARROW_W-1:0]  wdata_b,
  output logic [NARROW_W-1:0]  rdata_b
);

  generate
    if (!cfg_is_legal(RATIO, WIDE_W, WIDE_DEPTH)) begin : g_bad_cfg
      $error("asym_dpram: RATIO must be 1/2/4/8 dividing WIDE_W, WIDE_DEPTH a power of two >= 2");
    end
  endgenerate

  logic                     rst_q_n;
  acc_kind_e                kind_a, kind_b;
  logic                     rd_a, wr_a, rd_b, wr_b;
  logic [ROW_AW-1:0]        row_b;
  logic [SEL_W-1:0]         lane_b;
  logic [SEL_W-1:0]         sel_q, sel_d;
  logic [RATIO-1:0]         lane_wr_b;
  logic [RATIO*NARROW_W-1:0] lanes_b;

  asym_dpram_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  asym_dpram_port_ctl i_ctl_a (.en(en_a), .we(we_a), .kind(kind_a), .rd(rd_a), .wr(wr_a));
  asym_dpram_port_ctl i_ctl_b (.en(en_b), .we(we_b), .kind(kind_b), .rd(rd_b), .wr(wr_b));

  // Narrow address: row bits on top, lane-select bits at the bottom.
  assign row_b = addr_b[NARROW_AW-1:LANE_AW];

  generate
    if (LANE_AW > 0) begin : g_lane_bits
      assign lane_b = addr_b[LANE_AW-1:0];
    end else begin : g_no_lane_bits
      assign lane_b = '0;
    end
  endgenerate

  generate
    for (genvar i = 0; i < RATIO; i++) begin : g_lane
      assign lane_wr_b[i] = wr_b && (lane_b == SEL_W'(i));

      asym_dpram_lane_bank #(
        .LANE_W (NARROW_W),
        .DEPTH  (WIDE_DEPTH)
      ) i_bank (
        .clk     (clk),
        .rst_n   (rst_q_n),
        .a_rd    (rd_a),
        .a_wr    (wr_a),
        .a_row   (addr_a),
        .a_wdata (wdata_a[i*NARROW_W +: NARROW_W]),
        .a_rdata (rdata_a[i*NARROW_W +: NARROW_W]),
        .b_rd    (rd_b),
        .b_wr    (lane_wr_b[i]),
        .b_row   (row_b),
        .b_wdata (wdata_b),
        .b_rdata (lanes_b[i*NARROW_W +: NARROW_W])
      );
    end
  endgenerate

  // Lane select follows the read data one edge behind the address.
  always_comb begin
    sel_d = sel_q;
    if (rd_b) begin
      sel_d = lane_b;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sel_q <= '0;
    end else begin
      sel_q <= sel_d;
    end
  end

  asym_dpram_lane_mux #(
    .LANE_W (NARROW_W),
    .RATIO  (RATIO)
  ) i_mux (
    .lanes (lanes_b),
    .sel   (sel_q),
    .out   (rdata_b)
  );

  p_a_hold_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    !en_a |=> $stable(rdata_a));

  p_b_hold_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    !en_b |=> $stable(rdata_b));

  p_lane_onehot_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0(lane_wr_b));

  p_wide_wr_rd_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_a ##1 (en_a && !we_a && (addr_a == $past(addr_a)) && !wr_b))
      |=> (rdata_a == $past(wdata_a, 2)));

endmodule

// File: tb/test_asym_dpram.sv
module test_asym_dpram;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WW  = 32;
  localparam int unsigned RT  = 4;
  localparam int unsigned DP  = 16;
  localparam int unsigned NW  = WW / RT;
  localparam int unsigned RAW = $clog2(DP);
  localparam int unsigned LAW = $clog2(RT);
  localparam int unsigned NAW = RAW + LAW;
  localparam int unsigned ND  = DP * RT;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           en_a, we_a, en_b, we_b;
  logic [RAW-1:0] addr_a;
  logic [WW-1:0]  wdata_a, rdata_a;
  logic [NAW-1:0] addr_b;
  logic [NW-1:0]  wdata_b, rdata_b;

  logic [WW-1:0]  model [DP];
  logic [WW-1:0]  exp_a;
  logic [NW-1:0]  exp_b;
  int             checks = 0;
  int             failures = 0;
  bit             done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asym_dpram #(.WIDE_W(WW), .RATIO(RT), .WIDE_DEPTH(DP)) i_asym_dpram (
    .clk(clk), .rst_n(rst_n),
    .en_a(en_a), .we_a(we_a), .addr_a(addr_a), .wdata_a(wdata_a), .rdata_a(rdata_a),
    .en_b(en_b), .we_b(we_b), .addr_b(addr_b), .wdata_b(wdata_b), .rdata_b(rdata_b)
  );

  function automatic logic [NW-1:0] lane_of(input logic [WW-1:0] w, input int lane);
    return NW'(w >> (lane * NW));
  endfunction

  function automatic logic [WW-1:0] put_lane(input logic [WW-1:0] w, input int lane,
                                             input logic [NW-1:0] v);
    logic [WW-1:0] mask;
    mask = {{(WW-NW){1'b0}}, {NW{1'b1}}} << (lane * NW);
    return (w & ~mask) | ((WW'(v) << (lane * NW)) & mask);
  endfunction

  task automatic chk_a(input string req);
    checks++;
    if (!$isunknown(exp_a) && rdata_a !== exp_a) begin
      failures++;
      $display("FAIL %s rdata_a actual=%h expected=%h", req, rdata_a, exp_a);
    end
  endtask

  task automatic chk_b(input string req);
    checks++;
    if (!$isunknown(exp_b) && rdata_b !== exp_b) begin
      failures++;
      $display("FAIL %s rdata_b actual=%h expected=%h", req, rdata_b, exp_b);
    end
  endtask

  // Apply current inputs for one edge, update model, check both outputs.
  task automatic cycle(input string ra, input string rb);
    int row;
    int lane;
    row  = int'(addr_b) / RT;
    lane = int'(addr_b) % RT;
    if (en_a) exp_a = model[addr_a];
    if (en_b) exp_b = lane_of(model[row], lane);
    if (en_a && we_a) model[addr_a] = wdata_a;
    if (en_b && we_b) model[row] = put_lane(model[row], lane, wdata_b);
    @(posedge clk);
    #1;
    chk_a(ra);
    chk_b(rb);
  endtask

  task automatic idle();
    en_a = 1'b0; we_a = 1'b0; en_b = 1'b0; we_b = 1'b0;
  endtask

  task automatic rd_a(input int row);
    idle(); en_a = 1'b1; addr_a = RAW'(row);
  endtask

  task automatic rd_b(input int addr);
    en_b = 1'b1; we_b = 1'b0; addr_b = NAW'(addr);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle();
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    exp_a = '0;
    exp_b = '0;
    chk_a("R8");
    chk_b("R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    addr_a = '0; addr_b = '0; wdata_a = '0; wdata_b = '0;
    do_reset();

    // R1: fill every wide row, then read all back.
    for (int r = 0; r < DP; r++) begin
      idle(); en_a = 1'b1; we_a = 1'b1; addr_a = RAW'(r); wdata_a = $urandom;
      cycle("R1", "R1");
    end
    for (int r = 0; r < DP; r++) begin
      rd_a(r);
      cycle("R1", "R1");
    end

    // R2: every narrow address reads its lane slice.
    for (int n = 0; n < ND; n++) begin
      idle(); rd_b(n);
      cycle("R2", "R2");
    end

    // R3: narrow writes into lane 0 and top lane of row 3, wide read of the rest.
    idle(); en_b = 1'b1; we_b = 1'b1; addr_b = NAW'(3*RT); wdata_b = 8'h11;
    cycle("R3", "R3");
    idle(); en_b = 1'b1; we_b = 1'b1; addr_b = NAW'(3*RT + RT - 1); wdata_b = 8'hEE;
    cycle("R3", "R3");
    rd_a(3);
    cycle("R3", "R3");

    // R4: top narrow address and address zero.
    idle(); en_b = 1'b1; we_b = 1'b1; addr_b = NAW'(ND-1); wdata_b = 8'h5C;
    cycle("R4", "R4");
    rd_a(DP-1); rd_b(ND-1);
    cycle("R4", "R4");
    idle(); rd_b(0);
    cycle("R4", "R4");

    // R5: read-first on the same port and across ports.
    idle(); en_a = 1'b1; we_a = 1'b1; addr_a = 4'd2; wdata_a = 32'hCAFE_F00D;
    rd_b(2*RT + 1);
    cycle("R5", "R5");
    idle(); en_b = 1'b1; we_b = 1'b1; addr_b = NAW'(9); wdata_b = 8'h7E;
    cycle("R5", "R5");
    rd_a(2); rd_b(9);
    cycle("R5", "R5");

    // R6: disabled ports ignore write strobes, outputs hold.
    idle(); we_a = 1'b1; addr_a = 4'd4; wdata_a = 32'hDEAD_BEEF;
    we_b = 1'b1; addr_b = NAW'(4*RT); wdata_b = 8'hAB;
    cycle("R6", "R6");
    rd_a(4); rd_b(4*RT);
    cycle("R6", "R6");

    // R7: simultaneous writes to disjoint bits.
    idle(); en_a = 1'b1; we_a = 1'b1; addr_a = 4'd5; wdata_a = 32'h0123_4567;
    en_b = 1'b1; we_b = 1'b1; addr_b = NAW'(6*RT + 2); wdata_b = 8'h9A;
    cycle("R7", "R7");
    rd_a(5); rd_b(6*RT + 2);
    cycle("R7", "R7");
    rd_a(6); rd_b(5*RT + 3);
    cycle("R7", "R7");

    // R8: reset clears read data but keeps contents.
    do_reset();
    rd_a(5); rd_b(6*RT + 2);
    cycle("R8", "R8");

    // Random mixed traffic, overlapping same-row writes avoided.
    for (int k = 0; k < 3000; k++) begin
      en_a = 1'($urandom); we_a = 1'($urandom); addr_a = RAW'($urandom); wdata_a = $urandom;
      en_b = 1'($urandom); we_b = 1'($urandom); addr_b = NAW'($urandom); wdata_b = NW'($urandom);
      if (en_a && we_a && en_b && we_b && (int'(addr_b) / RT == int'(addr_a))) we_b = 1'b0;
      cycle("R1", "R2");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule